// File: doc/BRIEF.md
# Serial Boot Configuration Sequencer

This block brings a filter core up without a host processor. During reset it samples a boot-select pin. If the pin was high, it becomes the master of a serial EEPROM. It clocks out a read request for a fixed script address and then keeps reading bytes. The bytes are grouped into 24-bit words and interpreted as a command script. Each decoded command is presented to the filter core on a parallel port as a kind code, an address and a data word, with a one-cycle valid pulse.

If the pin was low, the block leaves the serial lines idle and flags host mode, so an external microcontroller can configure the core.

Reading stops when the script issues its start command; the block then raises a done flag. An unknown command, or a script that runs past a byte limit without starting the filter, raises an error flag and releases the EEPROM.

Top module: `bootseq_top`

## Requirements
- R1: The level of `boot_sel_i` in the last reset cycle selects the mode, and later changes of that pin have no effect. When the level is low, `host_mode_o` is 1, `spi_cs_n_o` stays 1, `spi_sck_o` stays 0, and no command, done or error is produced. During reset `spi_cs_n_o` is 1 and `spi_sck_o`, `cmd_valid_o`, `done_o` and `err_o` are 0.
- R2: When the level is high, chip select goes low and the block first sends the byte 0x03 and then the 16-bit `EE_BASE` address, high byte first. All bytes are sent MSB first in SPI mode 0: MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R3: Script bytes are grouped three at a time into a 24-bit word, with the first byte as bits 23:16. A command is a word whose value is its opcode.
- R4: Opcode 1 consumes an address word and then a data word. It issues one command of kind 1, whose address is the low `ADDR_W` bits of the address word and whose data is the data word.
- R5: Opcode 2 consumes a count N1 and a count N2, each taking the low `ADDR_W`-1 bits of its word. It then issues N1+N2 commands of kind 2, one per following word. The k-th word of the first set has address k with MSB 0; the k-th word of the second set has address k with MSB 1. Zero counts issue nothing.
- R6: Opcode 3 consumes eight words and issues eight commands of kind 3 with addresses 0 to 7. The coefficient order is a11, b10, b11, a21, a22, b20, b21, b22.
- R7: Opcode 4 consumes one word and issues one command of kind 4 carrying it unchanged. In that word, bits 3:0 select the FIR1 set, bits 7:4 the FIR2 set and bits 11:8 the IIR set.
- R8: Opcode 8 issues one command of kind 5. `done_o` then rises and stays high, chip select returns high, and no further SCK edges occur.
- R9: Opcode 9 issues one command of kind 6 and reading continues.
- R10: Opcodes 0, 5, 6 and 7 issue no command and reading continues.
- R11: An opcode above 9 issues no command. `err_o` rises and stays high, chip select returns high, and reading stops.
- R12: If byte number `MAX_BYTES` of the script (header not counted) is read without completing a start command, `err_o` rises and reading stops. Exactly `MAX_BYTES` script bytes are clocked in that case.
- R13: `cmd_valid_o` is never high on two consecutive cycles, and `done_o` and `err_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel_i | input | 1 | Boot source select, sampled during reset |
| spi_cs_n_o | output | 1 | EEPROM chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to EEPROM |
| spi_miso_i | input | 1 | Serial data from EEPROM |
| host_mode_o | output | 1 | High when the microcontroller boot mode was selected |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_kind_o | output | 3 | Command kind: 1 reg, 2 FIR coef, 3 IIR coef, 4 select, 5 start, 6 stop |
| cmd_addr_o | output | ADDR_W | Register address or coefficient index |
| cmd_data_o | output | 24 | Command data word |
| done_o | output | 1 | Script finished with a start command |
| err_o | output | 1 | Unknown opcode or byte limit reached |

## Verification
A wrong word phase or a wrong parser state shows up at the next command strobe as a wrong kind, address or data value. At the latest it shows when done or error is raised at the end of the script. The bench predicts every strobe from the script it loads into its EEPROM model and compares each strobe in the cycle it occurs, so a misaligned byte count is visible within one command. Faults in the serial engine show as a wrong captured header, MOSI moving while SCK is high, or SCK edges after the end.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_REG   = 3'd1,
        K_FIR   = 3'd2,
        K_IIR   = 3'd3,
        K_SEL   = 3'd4,
        K_START = 3'd5,
        K_STOP  = 3'd6
    } cmd_kind_e;

    typedef enum logic [3:0] {
        P_OP, P_REG_A, P_REG_D, P_FIR_N1, P_FIR_N2, P_FIR_C,
        P_IIR, P_SEL, P_DONE, P_ERR
    } parse_st_e;

    typedef enum logic [2:0] {
        L_IDLE, L_HDR, L_HDRW, L_GAP, L_RD, L_END
    } link_st_e;

    localparam logic [7:0]  EE_READ_CMD = 8'h03;
    localparam logic [23:0] OP_REG      = 24'd1;
    localparam logic [23:0] OP_FIR      = 24'd2;
    localparam logic [23:0] OP_IIR      = 24'd3;
    localparam logic [23:0] OP_SEL      = 24'd4;
    localparam logic [23:0] OP_START    = 24'd8;
    localparam logic [23:0] OP_STOP     = 24'd9;
    localparam int          IIR_WORDS   = 8;

    function automatic logic op_is_nop(input logic [23:0] w);
        return (w == 24'd0) || (w == 24'd5) || (w == 24'd6) || (w == 24'd7);
    endfunction

endpackage

// File: rtl/bootseq_spi.sv
module bootseq_spi #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       done_o,
    output logic [7:0] rx_o,
    output logic       sck_o,
    output logic       mosi_o
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q, rx_q;
    logic          sck_q, busy_q, done_q;
    logic          tick;

    assign tick = (div_q == DW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            sck_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    sh_q   <= tx_i;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (tick) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso_i};
                end else begin
                    sck_q <= 1'b0;
                    sh_q  <= {sh_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign done_o = done_q;
    assign rx_o   = rx_q;
    assign sck_o  = sck_q;
    assign mosi_o = sh_q[7];

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sck_q |-> $stable(sh_q[7]));

endmodule

// File: rtl/bootseq_parse.sv
module bootseq_parse
    import bootseq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MAX_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              cmd_valid_o,
    output cmd_kind_e         cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [23:0]       cmd_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int CW  = ADDR_W - 1;
    localparam int BCW = $clog2(MAX_BYTES + 1);

    parse_st_e         st_q;
    logic [1:0]        bpos_q;
    logic [15:0]       acc_q;
    logic [CW-1:0]     n1_q, n2_q;
    logic [ADDR_W-1:0] idx_q, ra_q;
    logic [BCW-1:0]    nbytes_q;
    logic              vld_q;
    cmd_kind_e         kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [23:0]       data_q;

    logic [23:0]       word;
    logic              active, last_byte, limit_hit;
    logic [ADDR_W-1:0] total, fir_addr, n1_ext;

    assign word      = {acc_q, byte_i};
    assign active    = (st_q != P_DONE) && (st_q != P_ERR);
    assign last_byte = (bpos_q == 2'd2);
    assign limit_hit = (nbytes_q == BCW'(MAX_BYTES - 1)) &&
                       !(last_byte && st_q == P_OP && word == OP_START);
    assign n1_ext    = ADDR_W'(n1_q);
    assign total     = n1_ext + ADDR_W'(n2_q);
    assign fir_addr  = (idx_q < n1_ext) ? {1'b0, idx_q[CW-1:0]}
                                        : {1'b1, CW'(idx_q - n1_ext)};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= P_OP;
            bpos_q   <= '0;
            acc_q    <= '0;
            n1_q     <= '0;
            n2_q     <= '0;
            idx_q    <= '0;
            ra_q     <= '0;
            nbytes_q <= '0;
            vld_q    <= 1'b0;
            kind_q   <= K_NONE;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            vld_q <= 1'b0;
            if (byte_valid_i && active) begin
                nbytes_q <= nbytes_q + BCW'(1);
                acc_q    <= {acc_q[7:0], byte_i};
                bpos_q   <= last_byte ? 2'd0 : bpos_q + 2'd1;
                if (last_byte) begin
                    unique case (st_q)
                        P_OP: begin
                            if (word == OP_REG)      st_q <= P_REG_A;
                            else if (word == OP_FIR) st_q <= P_FIR_N1;
                            else if (word == OP_IIR) begin
                                st_q  <= P_IIR;
                                idx_q <= '0;
                            end
                            else if (word == OP_SEL) st_q <= P_SEL;
                            else if (word == OP_START || word == OP_STOP) begin
                                vld_q  <= 1'b1;
                                kind_q <= (word == OP_START) ? K_START : K_STOP;
                                addr_q <= '0;
                                data_q <= '0;
                                if (word == OP_START) st_q <= P_DONE;
                            end
                            else if (!op_is_nop(word)) st_q <= P_ERR;
                        end
                        P_REG_A: begin
                            ra_q <= word[ADDR_W-1:0];
                            st_q <= P_REG_D;
                        end
                        P_REG_D: begin
                            vld_q  <= 1'b1;
                            kind_q <= K_REG;
                            addr_q <= ra_q;
                            data_q <= word;
                            st_q   <= P_OP;
                        end
                        P_FIR_N1: begin
                            n1_q <= word[CW-1:0];
                            st_q <= P_FIR_N2;
                        end
                        P_FIR_N2: begin
                            n2_q  <= word[CW-1:0];
                            idx_q <= '0;
                            st_q  <= (n1_ext + ADDR_W'(word[CW-1:0]) == '0) ? P_OP : P_FIR_C;
                        end
                        P_FIR_C: begin
                            vld_q  <= 1'b1;
                            kind_q <= K_FIR;
                            addr_q <= fir_addr;
                            data_q <= word;
                            idx_q  <= idx_q + ADDR_W'(1);
                            if (idx_q + ADDR_W'(1) == total) st_q <= P_OP;
                        end
                        P_IIR: begin
                            vld_q  <= 1'b1;
                            kind_q <= K_IIR;
                            addr_q <= idx_q;
                            data_q <= word;
                            idx_q  <= idx_q + ADDR_W'(1);
                            if (idx_q == ADDR_W'(IIR_WORDS - 1)) st_q <= P_OP;
                        end
                        P_SEL: begin
                            vld_q  <= 1'b1;
                            kind_q <= K_SEL;
                            addr_q <= '0;
                            data_q <= word;
                            st_q   <= P_OP;
                        end
                        default: ;
                    endcase
                end
                if (limit_hit) st_q <= P_ERR;
            end
        end
    end

    assign cmd_valid_o = vld_q;
    assign cmd_kind_o  = kind_q;
    assign cmd_addr_o  = addr_q;
    assign cmd_data_o  = data_q;
    assign done_o      = (st_q == P_DONE);
    assign err_o       = (st_q == P_ERR);

    // R13
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));
    // R13
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
    // R8
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && !cmd_valid_o));

endmodule

// File: rtl/bootseq_top.sv
module bootseq_top
    import bootseq_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          SPI_DIV   = 2,
    parameter logic [15:0] EE_BASE   = 16'h0000,
    parameter int          MAX_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_sel_i,
    output logic              spi_cs_n_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic              host_mode_o,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_kind_o,
    output logic [ADDR_W-1:0] cmd_addr_o,
    output logic [23:0]       cmd_data_o,
    output logic              done_o,
    output logic              err_o
);
    link_st_e   st_q;
    logic       boot_q;
    logic [1:0] hdr_q;
    logic       spi_start, spi_done;
    logic [7:0] spi_tx, spi_rx;
    logic       p_done, p_err, byte_vld;
    cmd_kind_e  p_kind;

    always_ff @(posedge clk) begin
        if (rst) boot_q <= boot_sel_i;
    end

    always_comb begin
        unique case (hdr_q)
            2'd0:    spi_tx = EE_READ_CMD;
            2'd1:    spi_tx = EE_BASE[15:8];
            default: spi_tx = EE_BASE[7:0];
        endcase
        if (st_q != L_HDR) spi_tx = 8'h00;
    end

    assign spi_start = (st_q == L_HDR) || (st_q == L_GAP && !p_done && !p_err);
    assign byte_vld  = spi_done && (st_q == L_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= L_IDLE;
            hdr_q <= '0;
        end else begin
            unique case (st_q)
                L_IDLE: if (boot_q) st_q <= L_HDR;
                L_HDR:  st_q <= L_HDRW;
                L_HDRW: if (spi_done) begin
                    if (hdr_q == 2'd2) st_q <= L_GAP;
                    else begin
                        hdr_q <= hdr_q + 2'd1;
                        st_q  <= L_HDR;
                    end
                end
                L_GAP:  st_q <= (p_done || p_err) ? L_END : L_RD;
                L_RD:   if (spi_done) st_q <= L_GAP;
                default: ;
            endcase
        end
    end

    bootseq_spi #(.DIV(SPI_DIV)) u_spi (
        .clk(clk), .rst(rst), .start_i(spi_start), .tx_i(spi_tx),
        .miso_i(spi_miso_i), .done_o(spi_done), .rx_o(spi_rx),
        .sck_o(spi_sck_o), .mosi_o(spi_mosi_o)
    );

    bootseq_parse #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_parse (
        .clk(clk), .rst(rst), .byte_valid_i(byte_vld), .byte_i(spi_rx),
        .cmd_valid_o(cmd_valid_o), .cmd_kind_o(p_kind), .cmd_addr_o(cmd_addr_o),
        .cmd_data_o(cmd_data_o), .done_o(p_done), .err_o(p_err)
    );

    assign cmd_kind_o  = p_kind;
    assign spi_cs_n_o  = (st_q == L_IDLE) || (st_q == L_END);
    assign host_mode_o = !boot_q;
    assign done_o      = p_done;
    assign err_o       = p_err;

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n_o |-> !spi_sck_o);
    // R1
    host_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        host_mode_o |-> (spi_cs_n_o && !cmd_valid_o));
    // R8
    release_on_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == L_END) |=> spi_cs_n_o);

endmodule

// File: tb/bootseq_top_tb.sv
`timescale 1ns/1ps
module bootseq_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_sel = 1'b0;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        host_mode, cmd_valid, done, err;
    logic [2:0]  cmd_kind;
    logic [7:0]  cmd_addr;
    logic [23:0] cmd_data;

    always #2.5 clk = ~clk;

    bootseq_top #(.ADDR_W(8), .SPI_DIV(2), .EE_BASE(16'h0000), .MAX_BYTES(128)) u_dut (
        .clk(clk), .rst(rst), .boot_sel_i(boot_sel),
        .spi_cs_n_o(spi_cs_n), .spi_sck_o(spi_sck), .spi_mosi_o(spi_mosi),
        .spi_miso_i(spi_miso), .host_mode_o(host_mode),
        .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_addr_o(cmd_addr),
        .cmd_data_o(cmd_data), .done_o(done), .err_o(err)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int    kind;
        int    addr;
        int    data;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // EEPROM model
    logic [7:0]  mem [256];
    int          wp;
    int          sb;
    int          extra_edges;
    int          mosi_viol;
    int          cs_low_seen;
    logic [23:0] hdr_cap;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_all();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_all();
        end
    end

    always @(negedge spi_cs_n) begin
        sb = 0;
        cs_low_seen++;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (sb < 24) hdr_cap = {hdr_cap[22:0], spi_mosi};
            sb++;
            if (done || err) extra_edges++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && sb >= 24) begin
            int k;
            k = sb - 24;
            spi_miso = mem[(int'(hdr_cap[15:0]) + k / 8) % 256][7 - (k % 8)];
        end
    end

    always @(spi_mosi) begin
        if (spi_sck === 1'b1 && spi_cs_n === 1'b0) mosi_viol++;
    end

    // per-cycle reference compare of the command port
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (!rst && cmd_valid) begin
            // R13 strobe spacing is checked together with the content
            if (exp_q.size() == 0) begin
                check(1'b0, "R4-unexpected command", int'(cmd_kind), 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(cmd_kind) == e.kind && int'(cmd_addr) == e.addr &&
                      int'(cmd_data) == e.data && !prev_valid, e.tag,
                      {int'(cmd_kind), 8'(cmd_addr), cmd_data[15:0]},
                      {e.kind, 8'(e.addr), 16'(e.data)});
            end
        end
        prev_valid = rst ? 1'b0 : cmd_valid;
    end

    task automatic put_word(input int w);
        mem[wp]     = 8'(w >> 16);
        mem[wp + 1] = 8'(w >> 8);
        mem[wp + 2] = 8'(w);
        wp += 3;
    endtask

    task automatic expect_cmd(input int k, input int a, input int d, input string tag);
        exp_t e;
        e.kind = k; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wp = 0;
    endtask

    task automatic do_reset(input logic b);
        @(negedge clk);
        rst = 1'b1;
        boot_sel = b;
        extra_edges = 0;
        mosi_viol = 0;
        cs_low_seen = 0;
        hdr_cap = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_end(input int lim);
        int n;
        n = 0;
        while (!(done || err) && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        // ---------------- run A: full script ----------------
        clear_mem();
        put_word(24'h000000);                         // R10 nop
        put_word(24'h000001); put_word(24'h000021); put_word(24'hA5B6C7);
        expect_cmd(1, 8'h21, 24'hA5B6C7, "R4/R3 register write");
        put_word(24'h000002); put_word(24'h000002); put_word(24'h000001);
        put_word(24'h7FFFFF); put_word(24'h123456); put_word(24'h800001);
        expect_cmd(2, 8'h00, 24'h7FFFFF, "R5 FIR1 coef 0");
        expect_cmd(2, 8'h01, 24'h123456, "R5 FIR1 coef 1");
        expect_cmd(2, 8'h80, 24'h800001, "R5 FIR2 coef 0");
        put_word(24'h000002); put_word(24'h000000); put_word(24'h000000); // R5 empty
        put_word(24'h000003);
        for (int i = 0; i < 8; i++) begin
            put_word(24'h100000 + i);
            expect_cmd(3, i, 24'h100000 + i, "R6 IIR coefficient order");
        end
        put_word(24'h000005);                         // R10 nop
        put_word(24'h000004); put_word(24'h000321);
        expect_cmd(4, 0, 24'h000321, "R7 set select word");
        put_word(24'h000009);
        expect_cmd(6, 0, 0, "R9 stop command");
        put_word(24'h000006); put_word(24'h000007);   // R10 nops
        put_word(24'h000008);
        expect_cmd(5, 0, 0, "R8 start command");
        put_word(24'h00000A);                         // must never be read

        do_reset(1'b1);
        rst = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && cmd_valid == 1'b0 &&
              done == 1'b0 && err == 1'b0, "R1 reset state",
              {spi_cs_n, spi_sck, cmd_valid, done, err}, 5'b10000);
        rst = 1'b0;
        @(negedge clk);
        check(host_mode == 1'b0, "R1 eeprom mode selected", host_mode, 0);
        wait_end(20000);
        @(negedge clk);
        check(done == 1'b1 && err == 1'b0, "R8 done after start", {done, err}, 2'b10);
        check(hdr_cap == 24'h030000, "R2 read header", hdr_cap, 24'h030000);
        check(mosi_viol == 0, "R2 mode 0 MOSI timing", mosi_viol, 0);
        repeat (200) @(negedge clk);
        check(extra_edges == 0 && spi_cs_n == 1'b1, "R8 no clocks after done",
              extra_edges, 0);
        check(err == 1'b0 && done == 1'b1, "R8 trailing word ignored", {done, err}, 2'b10);
        check(exp_q.size() == 0, "R4-R9 all commands seen", exp_q.size(), 0);
        exp_q.delete();

        // ---------------- run B: unknown opcode ----------------
        clear_mem();
        put_word(24'h000001); put_word(24'h000005); put_word(24'h00BEEF);
        expect_cmd(1, 8'h05, 24'h00BEEF, "R4 register write before error");
        put_word(24'h00000C);
        put_word(24'h000001); put_word(24'h000006); put_word(24'h000001);
        do_reset(1'b1);
        wait_end(20000);
        repeat (100) @(negedge clk);
        check(err == 1'b1 && done == 1'b0, "R11 error on unknown opcode", {done, err}, 2'b01);
        check(spi_cs_n == 1'b1 && extra_edges == 0, "R11 EEPROM released",
              extra_edges, 0);
        check(exp_q.size() == 0, "R11 no command from unknown opcode", exp_q.size(), 0);
        exp_q.delete();

        // ---------------- run C: byte limit ----------------
        clear_mem();                                  // all words are nop (R10)
        do_reset(1'b1);
        n = 0;
        while (sb < 24 + 8 * 100 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(err == 1'b0 && done == 1'b0, "R12 no error before limit / R10 nops",
              {done, err}, 2'b00);
        wait_end(20000);
        repeat (100) @(negedge clk);
        check(err == 1'b1, "R12 error at byte limit", err, 1);
        check(sb == 24 + 8 * 128, "R12 script bytes clocked", (sb - 24) / 8, 128);

        // ---------------- run D: host mode ----------------
        clear_mem();
        put_word(24'h000008);
        do_reset(1'b0);
        @(negedge clk);
        boot_sel = 1'b1;                              // R1 late change ignored
        repeat (500) @(negedge clk);
        check(host_mode == 1'b1, "R1 host mode flag", host_mode, 1);
        check(cs_low_seen == 0 && spi_cs_n == 1'b1 && spi_sck == 1'b0,
              "R1 serial lines idle", cs_low_seen, 0);
        check(done == 1'b0 && err == 1'b0, "R1 no done or error in host mode",
              {done, err}, 2'b00);

        finish_all();
    end

endmodule